// File: doc/BRIEF.md
# Pointer-Chasing Memory Walker

This block walks a linked chain of addresses held in an on-chip memory. Every word it reads tells it where to go next. In jump mode the word itself becomes the next address. In add mode the word is an offset added to the current address. The memory has a registered read port, so the data for an address only appears one clock edge after the address is presented. The next address cannot be known until that data arrives, so successive reads cannot overlap. A small sequencer therefore alternates between presenting an address and capturing the word it returns, and each step of the walk takes two clock cycles.

Before a walk, the memory is preloaded through a write port that is only honoured while the walker is idle. A single-cycle start pulse loads a start address and latches the mode for the whole walk. Each visited step is reported for one cycle on a valid strobe, together with the address visited and the word read there. A stop request ends the walk once the current capture has finished.

The sequencer has three states:
- ST_IDLE waits for a start.
- ST_ISSUE presents the current address to the memory.
- ST_CAPTURE holds the returned word and computes the next address.

It has four transitions:
- IDLE to ISSUE on an accepted start.
- ISSUE to CAPTURE always.
- CAPTURE to ISSUE when no stop is requested.
- CAPTURE to IDLE when a stop has been requested.

Top module: `ptr_walker`

## Requirements
- R1: A synchronous reset returns the walker to ST_IDLE, clears `cur_addr` to zero and holds `step_valid` low, including when it arrives in the middle of a walk.
- R2: A `start` pulse accepted in ST_IDLE loads `start_addr`. In the second cycle after the accepting edge, `step_valid` is high, `cur_addr` equals the start address and `step_data` equals the memory word at that address.
- R3: During a walk `step_valid` is high for exactly one cycle out of every two, and it is never high in two consecutive cycles.
- R4: In jump mode (`mode` = 0), the address after a step is the low `ADDR_W` bits of the word read; any higher data bits are discarded.
- R5: In add mode (`mode` = 1), the address after a step is the current address plus the low `ADDR_W` bits of the word read, modulo 2^`ADDR_W`.
- R6: `cur_addr` changes only on a rising edge that ends ST_CAPTURE, accepts a start, or applies reset; it is stable throughout ST_ISSUE.
- R7: A `stop` request seen in ST_ISSUE or ST_CAPTURE ends the walk at the end of the next capture. Afterwards `step_valid` stays low and `cur_addr` holds the computed next address until the next start.
- R8: A write (`wr_en`) presented while the walker is not in ST_IDLE leaves the memory unchanged.
- R9: A `start` pulse during a walk is ignored; the walk continues on its chain.
- R10: The mode is sampled only when a start is accepted; changing `mode` during a walk has no effect on that walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a walk (honoured in ST_IDLE only) |
| start_addr | input | ADDR_W | First address of the walk |
| mode | input | 1 | 0 = jump to word, 1 = add word to address |
| stop | input | 1 | End the walk after the pending capture |
| wr_en | input | 1 | Memory write enable (honoured in ST_IDLE only) |
| wr_addr | input | ADDR_W | Memory write address |
| wr_data | input | DATA_W | Memory write data |
| cur_addr | output | ADDR_W | Address register of the walker |
| step_data | output | DATA_W | Word read at the visited address |
| step_valid | output | 1 | One-cycle strobe marking a completed step |

## Verification
The memory is filled with random words and walked in both modes from random start addresses for random lengths. This exercises the jump and add arithmetic on chains that neither mode would produce by chance in the other. Directed chains cover a word with its upper bits set, which separates truncation from zero-extension, and an add step that passes the top of memory, which shows the address wraps. Writes, start pulses and mode changes are injected in the middle of walks; a design that honoured any of them would leave the next visited word or address different from the bench model. Stop requests arrive in both ISSUE and CAPTURE, and a reset arrives mid-walk, to tell the immediate exit apart from the deferred one.

// File: rtl/walker_pkg.sv
package walker_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ISSUE   = 2'd1,
        ST_CAPTURE = 2'd2
    } walk_state_e;

    typedef enum logic {
        MODE_JUMP = 1'b0,
        MODE_ADD  = 1'b1
    } walk_mode_e;

endpackage

// File: rtl/walk_ram.sv
module walk_ram #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // registered read port: one cycle of latency
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            rdata <= mem[raddr];
        end
    end
endmodule

// File: rtl/walk_seq.sv
module walk_seq
    import walker_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        stop,
    output walk_state_e state,
    output logic        load,
    output logic        issue,
    output logic        advance,
    output logic        idle
);
    walk_state_e state_d;
    logic        stop_pend;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_d;
        end
    end

    // a stop seen in ISSUE or CAPTURE is held until the capture ends
    always_ff @(posedge clk) begin
        if (rst || state == ST_IDLE) begin
            stop_pend <= 1'b0;
        end else if (stop) begin
            stop_pend <= 1'b1;
        end
    end

    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE:    if (start) state_d = ST_ISSUE;
            ST_ISSUE:   state_d = ST_CAPTURE;
            ST_CAPTURE: state_d = (stop || stop_pend) ? ST_IDLE : ST_ISSUE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from the state
    always_comb begin
        idle    = (state == ST_IDLE);
        issue   = (state == ST_ISSUE);
        advance = (state == ST_CAPTURE);
        load    = idle && start;
    end
endmodule

// File: rtl/walk_addr.sv
module walk_addr
    import walker_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              advance,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              load_mode,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] addr,
    output walk_mode_e        mode_q
);
    logic [ADDR_W-1:0] word_lo;
    logic [ADDR_W-1:0] next_addr;

    // truncate or zero-extend the word to the address width
    assign word_lo = ADDR_W'(rd_data);

    always_comb begin
        unique case (mode_q)
            MODE_JUMP: next_addr = word_lo;
            MODE_ADD:  next_addr = addr + word_lo;
            default:   next_addr = word_lo;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr   <= '0;
            mode_q <= MODE_JUMP;
        end else if (load) begin
            addr   <= load_addr;
            mode_q <= walk_mode_e'(load_mode);
        end else if (advance) begin
            addr   <= next_addr;
        end
    end
endmodule

// File: rtl/ptr_walker.sv
module ptr_walker
    import walker_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              mode,
    input  logic              stop,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [DATA_W-1:0] step_data,
    output logic              step_valid
);
    walk_state_e state;
    walk_mode_e  mode_q;
    logic        load;
    logic        issue;
    logic        advance;
    logic        idle;
    logic [DATA_W-1:0] rd_word;

    walk_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .stop    (stop),
        .state   (state),
        .load    (load),
        .issue   (issue),
        .advance (advance),
        .idle    (idle)
    );

    walk_addr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .advance   (advance),
        .load_addr (start_addr),
        .load_mode (mode),
        .rd_data   (rd_word),
        .addr      (cur_addr),
        .mode_q    (mode_q)
    );

    walk_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
        .clk   (clk),
        .we    (wr_en && idle),
        .waddr (wr_addr),
        .wdata (wr_data),
        .re    (issue),
        .raddr (cur_addr),
        .rdata (rd_word)
    );

    assign step_data  = rd_word;
    assign step_valid = advance;
endmodule

// File: rtl/walker_chk.sv
module walker_chk
    import walker_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              stop,
    input walk_state_e       state,
    input walk_mode_e        mode_q,
    input logic [ADDR_W-1:0] cur_addr,
    input logic [DATA_W-1:0] step_data,
    input logic              step_valid
);
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (cur_addr == '0 && !step_valid && state == ST_IDLE));

    // R2
    issue_then_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ISSUE) |=> step_valid);

    // R3
    no_back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
        step_valid |=> !step_valid);

    // R4
    jump_next_chk: assert property (@(posedge clk) disable iff (rst)
        (step_valid && mode_q == MODE_JUMP) |=>
            cur_addr == ADDR_W'($past(step_data)));

    // R5
    add_next_chk: assert property (@(posedge clk) disable iff (rst)
        (step_valid && mode_q == MODE_ADD) |=>
            cur_addr == ADDR_W'($past(cur_addr) + ADDR_W'($past(step_data))));

    // R6
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ISSUE) |=> $stable(cur_addr));

    // R7
    stop_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (step_valid && stop) |=> (state == ST_IDLE));
endmodule

bind ptr_walker walker_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .stop       (stop),
    .state      (state),
    .mode_q     (mode_q),
    .cur_addr   (cur_addr),
    .step_data  (step_data),
    .step_valid (step_valid)
);

// File: tb/ptr_walker_bench.sv
module ptr_walker_bench;
    localparam int AW    = 6;
    localparam int DW    = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic          mode = 1'b0;
    logic          stop = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] cur_addr;
    logic [DW-1:0] step_data;
    logic          step_valid;

    logic [DW-1:0] model [DEPTH];
    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    ptr_walker #(.ADDR_W(AW), .DATA_W(DW)) u_ptr_walker (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
        .mode(mode), .stop(stop), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cur_addr(cur_addr), .step_data(step_data),
        .step_valid(step_valid)
    );

    function automatic logic [AW-1:0] step_to(input logic [AW-1:0] a,
                                              input logic [DW-1:0] d,
                                              input bit m);
        logic [AW-1:0] lo;
        lo = d[AW-1:0];
        return m ? AW'(a + lo) : lo;
    endfunction

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic put_word(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        model[a] = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // A walk of n steps. Options inject a write (R8), a start (R9),
    // a mode flip (R10) or a stop raised in ISSUE instead of CAPTURE (R7).
    task automatic walk(input logic [AW-1:0] sa, input bit m, input int n,
                        input bit poke_wr, input bit poke_start,
                        input bit flip_mode, input bit early_stop);
        logic [AW-1:0] expa;
        logic [AW-1:0] nxt;
        @(negedge clk);
        start = 1'b1; start_addr = sa; mode = m;
        @(negedge clk);
        start = 1'b0;
        expa = sa;
        for (int i = 0; i < n; i++) begin
            if (poke_start && i == 1) begin
                start = 1'b1; start_addr = ~expa;
            end
            if (early_stop && i == n - 1) stop = 1'b1;
            @(negedge clk);
            start = 1'b0; stop = 1'b0;
            check("R2/R3 valid in capture", step_valid, 1);
            check(m ? "R5 visited address" : "R4 visited address", cur_addr, expa);
            check("R2 word read", step_data, model[expa]);
            nxt = step_to(expa, model[expa], m);
            if (!early_stop && i == n - 1) stop = 1'b1;
            if (poke_wr) begin
                wr_en = 1'b1; wr_addr = nxt; wr_data = ~model[nxt];
            end
            if (flip_mode) mode = ~m;
            @(negedge clk);
            stop = 1'b0; wr_en = 1'b0;
            expa = nxt;
            if (i < n - 1) check("R3 strobe low in issue", step_valid, 0);
        end
        check("R7 idle after stop", step_valid, 0);
        check("R7 address after stop", cur_addr, expa);
        repeat (3) @(negedge clk);
        check("R7 still idle", step_valid, 0);
        check("R6 address held in idle", cur_addr, expa);
        mode = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20511));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset address", cur_addr, 0);
        check("R1 reset strobe", step_valid, 0);

        for (int a = 0; a < DEPTH; a++) put_word(AW'(a), DW'($urandom));

        // R4: upper data bits dropped (0xC7 -> 7)
        put_word(6'd5, 8'hC7);
        put_word(6'd7, 8'h0A);
        walk(6'd5, 1'b0, 3, 1'b0, 1'b0, 1'b0, 1'b0);

        // R5: wrap past the top (60 + 10 -> 6)
        put_word(6'd60, 8'h0A);
        walk(6'd60, 1'b1, 4, 1'b0, 1'b0, 1'b0, 1'b0);

        // R8: writes during a walk, R9: start during a walk
        walk(6'd12, 1'b0, 6, 1'b1, 1'b1, 1'b0, 1'b0);
        walk(6'd33, 1'b1, 6, 1'b1, 1'b1, 1'b0, 1'b0);

        // R10: mode changes mid-walk
        walk(6'd20, 1'b0, 5, 1'b0, 1'b0, 1'b1, 1'b0);
        walk(6'd41, 1'b1, 5, 1'b0, 1'b0, 1'b1, 1'b0);

        // R7: stop raised during ISSUE
        walk(6'd2, 1'b1, 3, 1'b0, 1'b0, 1'b0, 1'b1);
        walk(6'd9, 1'b0, 1, 1'b0, 1'b0, 1'b0, 1'b1);

        // random walks
        for (int k = 0; k < 12; k++) begin
            walk(AW'($urandom), 1'($urandom), 1 + ($urandom % 20),
                 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        end

        // R1: reset in the middle of a walk
        @(negedge clk);
        start = 1'b1; start_addr = 6'd17; mode = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 mid-walk reset address", cur_addr, 0);
        check("R1 mid-walk reset strobe", step_valid, 0);
        repeat (2) @(negedge clk);
        check("R1 stays idle after reset", step_valid, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule